// File: doc/BRIEF.md
# Status Byte and Service-Request Generator

This block forms the 8-bit status byte an instrument presents to its bus controller and drives the service-request line. Two queue-occupancy flags (error queue, output queue) appear directly as status bits. Two event words, each with its own enable mask, are reduced to one summary bit each. Any enabled event bit that is set raises its summary.

A service-request enable register selects which status bits may produce a request. Their masked OR is the master summary. On a rising edge of that summary, a request latch sets and drives the request line. The latch clears on a serial poll or when the summary drops. Bit 6 of the byte has two views. A serial poll sees the latch. A query sees the live summary.

Every pin is a plain level or strobe. No pin carries a data stream, so no pin has a valid/ready handshake or back-pressure.

Top module: `srq_status_top`

## Requirements
- R1: Bits 0, 1 and 7 of both the poll byte and the query byte are always 0.
- R2: Bit 2 of both bytes equals the error-queue-not-empty input, and bit 4 equals the output-queue-not-empty input, in the same cycle.
- R3: Bit 3 of both bytes is 1 exactly when the extended event word ANDed with its mask is nonzero. Bit 5 is 1 exactly when the standard event word ANDed with its mask is nonzero.
- R4: Bit 6 of the query byte is the master summary. It is 1 exactly when status bits 0–5 and 7, ANDed with the enable register, give a nonzero result.
- R5: A write strobe loads the enable register at the clock edge. The readback shows the stored value. Bit 6 is always stored and read as 0 and never contributes to the summary.
- R6: The request latch sets at the first clock edge at which the summary is 1 and was 0 at the previous edge. The request output and bit 6 of the poll byte both equal the latch.
- R7: During a poll strobe, the poll byte carries the latch in bit 6. The latch is 0 after the clock edge that samples the strobe. A strobe at the same edge as a summary rise wins, so the latch stays 0.
- R8: The latch is 0 after any edge at which the summary is 0. It does not set again while the summary stays 1 after a poll.
- R9: A synchronous reset clears the enable register and the request latch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| err_q_nonempty | input | 1 | Error queue holds at least one entry |
| out_q_nonempty | input | 1 | Output queue holds data |
| std_evt | input | EVT_W | Standard event word |
| std_evt_en | input | EVT_W | Enable mask for the standard event word |
| ext_evt | input | EVT_W | Extended event word |
| ext_evt_en | input | EVT_W | Enable mask for the extended event word |
| sre_wr_en | input | 1 | Enable-register write strobe |
| sre_wr_data | input | 8 | Enable-register write value |
| poll_stb | input | 1 | Serial poll strobe, one cycle per poll |
| poll_byte | output | 8 | Status byte as a serial poll sees it (latch in bit 6) |
| query_byte | output | 8 | Status byte as a query sees it (summary in bit 6) |
| sre_rd | output | 8 | Enable-register readback |
| srq_out | output | 1 | Service-request line |

## Verification
The bench uses the default EVT_W of 8. At that width, any bit position of either event word can raise or hide a summary, depending on its mask. Directed sequences cover three cases: a summary held high across a poll, a poll that coincides with a summary rise, and a summary that drops and rises again. A long random phase then toggles the flags, the event words and the enable writes, so the summary rises, holds and falls in many different orders.

// File: rtl/srq_pkg.sv
package srq_pkg;
  localparam int SB_W    = 8;
  localparam int EAV_BIT = 2;
  localparam int EES_BIT = 3;
  localparam int MAV_BIT = 4;
  localparam int ESB_BIT = 5;
  localparam int SUM_BIT = 6;
  localparam int N_EVT   = 2;
  localparam int STD_IDX = 0;
  localparam int EXT_IDX = 1;
  typedef logic [SB_W-1:0] sbyte_t;
endpackage

// File: rtl/evt_summary.sv
module evt_summary #(
  parameter int W = 8
) (
  input  logic [W-1:0] evt,
  input  logic [W-1:0] en,
  output logic         hit
);
  assign hit = |(evt & en);
endmodule

// File: rtl/sre_reg.sv
module sre_reg #(
  parameter int W   = 8,
  parameter int IGN = 6
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         we,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  localparam logic [W-1:0] KEEP = ~(W'(1) << IGN);

  always_ff @(posedge clk) begin
    if (rst)     q <= '0;
    else if (we) q <= d & KEEP;
  end
endmodule

// File: rtl/rqs_latch.sv
module rqs_latch (
  input  logic clk,
  input  logic rst,
  input  logic mss,
  input  logic poll,
  output logic rqs
);
  logic mss_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      mss_q <= 1'b0;
      rqs   <= 1'b0;
    end else begin
      mss_q <= mss;
      if (!mss || poll) rqs <= 1'b0;
      else if (!mss_q)  rqs <= 1'b1;
    end
  end
endmodule

// File: rtl/srq_status_top.sv
module srq_status_top
  import srq_pkg::*;
#(
  parameter int EVT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             err_q_nonempty,
  input  logic             out_q_nonempty,
  input  logic [EVT_W-1:0] std_evt,
  input  logic [EVT_W-1:0] std_evt_en,
  input  logic [EVT_W-1:0] ext_evt,
  input  logic [EVT_W-1:0] ext_evt_en,
  input  logic             sre_wr_en,
  input  logic [7:0]       sre_wr_data,
  input  logic             poll_stb,
  output logic [7:0]       poll_byte,
  output logic [7:0]       query_byte,
  output logic [7:0]       sre_rd,
  output logic             srq_out
);
  logic [EVT_W-1:0] evt_w [N_EVT];
  logic [EVT_W-1:0] msk_w [N_EVT];
  logic [N_EVT-1:0] summ;
  sbyte_t           sre_q;
  sbyte_t           sb_base;
  logic             mss;
  logic             rqs;

  assign evt_w[STD_IDX] = std_evt;
  assign msk_w[STD_IDX] = std_evt_en;
  assign evt_w[EXT_IDX] = ext_evt;
  assign msk_w[EXT_IDX] = ext_evt_en;

  for (genvar g = 0; g < N_EVT; g++) begin : g_sum
    evt_summary #(.W(EVT_W)) u_sum (
      .evt (evt_w[g]),
      .en  (msk_w[g]),
      .hit (summ[g])
    );
  end

  sre_reg #(.W(SB_W), .IGN(SUM_BIT)) u_sre (
    .clk (clk),
    .rst (rst),
    .we  (sre_wr_en),
    .d   (sre_wr_data),
    .q   (sre_q)
  );

  always_comb begin
    sb_base          = '0;
    sb_base[EAV_BIT] = err_q_nonempty;
    sb_base[EES_BIT] = summ[EXT_IDX];
    sb_base[MAV_BIT] = out_q_nonempty;
    sb_base[ESB_BIT] = summ[STD_IDX];
  end

  assign mss = |(sb_base & sre_q);

  rqs_latch u_rqs (
    .clk  (clk),
    .rst  (rst),
    .mss  (mss),
    .poll (poll_stb),
    .rqs  (rqs)
  );

  always_comb begin
    query_byte          = sb_base;
    query_byte[SUM_BIT] = mss;
    poll_byte           = sb_base;
    poll_byte[SUM_BIT]  = rqs;
  end

  assign sre_rd  = sre_q;
  assign srq_out = rqs;
endmodule

// File: rtl/srq_status_chk.sv
module srq_status_chk (
  input logic       clk,
  input logic       rst,
  input logic       err_q_nonempty,
  input logic       poll_stb,
  input logic [7:0] poll_byte,
  input logic [7:0] query_byte,
  input logic [7:0] sre_rd,
  input logic       srq_out
);
  assert_zero_bits_R1: assert property (@(posedge clk) disable iff (rst)
    (poll_byte[7] == 1'b0) && (poll_byte[1:0] == 2'b00) &&
    (query_byte[7] == 1'b0) && (query_byte[1:0] == 2'b00));

  assert_eav_R2: assert property (@(posedge clk) disable iff (rst)
    poll_byte[2] == err_q_nonempty);

  assert_sre_bit6_R5: assert property (@(posedge clk) disable iff (rst)
    sre_rd[6] == 1'b0);

  assert_set_on_rise_R6: assert property (@(posedge clk) disable iff (rst)
    $rose(query_byte[6]) && !poll_stb |-> ##1 srq_out);

  assert_rise_needs_mss_R6: assert property (@(posedge clk) disable iff (rst)
    $rose(srq_out) |-> $past(query_byte[6]));

  assert_poll_clear_R7: assert property (@(posedge clk) disable iff (rst)
    poll_stb |=> !srq_out);

  assert_mss_low_clear_R8: assert property (@(posedge clk) disable iff (rst)
    !query_byte[6] |=> !srq_out);

  assert_reset_R9: assert property (@(posedge clk)
    rst |=> (sre_rd == 8'h00) && !srq_out);
endmodule

bind srq_status_top srq_status_chk i_chk (
  .clk            (clk),
  .rst            (rst),
  .err_q_nonempty (err_q_nonempty),
  .poll_stb       (poll_stb),
  .poll_byte      (poll_byte),
  .query_byte     (query_byte),
  .sre_rd         (sre_rd),
  .srq_out        (srq_out)
);

// File: tb/test_srq_status_top.sv
module test_srq_status_top;
  localparam int CLK_PERIOD = 10;
  localparam int EVT_W      = 8;
  localparam int WD_LIMIT   = 20000;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             err_q_nonempty = 1'b0;
  logic             out_q_nonempty = 1'b0;
  logic [EVT_W-1:0] std_evt = '0, std_evt_en = '0, ext_evt = '0, ext_evt_en = '0;
  logic             sre_wr_en = 1'b0;
  logic [7:0]       sre_wr_data = '0;
  logic             poll_stb = 1'b0;
  logic [7:0]       poll_byte, query_byte, sre_rd;
  logic             srq_out;

  int total = 0;
  int bad   = 0;
  int cycles = 0;

  logic [7:0] m_sre  = '0;
  logic       m_rqs  = 1'b0;
  logic       m_prev = 1'b0;

  srq_status_top #(.EVT_W(EVT_W)) i_srq_status_top (
    .clk(clk), .rst(rst),
    .err_q_nonempty(err_q_nonempty), .out_q_nonempty(out_q_nonempty),
    .std_evt(std_evt), .std_evt_en(std_evt_en),
    .ext_evt(ext_evt), .ext_evt_en(ext_evt_en),
    .sre_wr_en(sre_wr_en), .sre_wr_data(sre_wr_data),
    .poll_stb(poll_stb),
    .poll_byte(poll_byte), .query_byte(query_byte),
    .sre_rd(sre_rd), .srq_out(srq_out)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [7:0] exp_base();
    logic [7:0] b = 8'h00;
    b[2] = err_q_nonempty;
    b[3] = (ext_evt & ext_evt_en) != 0;
    b[4] = out_q_nonempty;
    b[5] = (std_evt & std_evt_en) != 0;
    return b;
  endfunction

  function automatic logic exp_mss();
    return (exp_base() & m_sre) != 0;
  endfunction

  // reference model, behavioural
  always @(posedge clk) begin
    logic mss_now;
    mss_now = exp_mss();
    if (rst) begin
      m_sre = '0; m_rqs = 1'b0; m_prev = 1'b0;
    end else begin
      if (!mss_now || poll_stb) m_rqs = 1'b0;
      else if (!m_prev)         m_rqs = 1'b1;
      m_prev = mss_now;
      if (sre_wr_en) m_sre = sre_wr_data & 8'hBF;
    end
  end

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h at t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic compare_all();
    logic [7:0] b;
    b = exp_base();
    chk("R1", {poll_byte[7], query_byte[7], poll_byte[1:0], query_byte[1:0]}, 8'h00);
    chk("R2", {6'b0, query_byte[4], query_byte[2]}, {6'b0, b[4], b[2]});
    chk("R3", {6'b0, query_byte[5], query_byte[3]}, {6'b0, b[5], b[3]});
    chk("R3 poll view", {6'b0, poll_byte[5], poll_byte[3]}, {6'b0, b[5], b[3]});
    chk("R4", {7'b0, query_byte[6]}, {7'b0, exp_mss()});
    chk("R5", sre_rd, m_sre);
    chk("R6", {6'b0, poll_byte[6], srq_out}, {6'b0, m_rqs, m_rqs});
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
    if (!rst) compare_all();
  endtask

  task automatic write_sre(input logic [7:0] v);
    sre_wr_en = 1'b1; sre_wr_data = v;
    step();
    sre_wr_en = 1'b0;
  endtask

  initial begin : watchdog
    repeat (WD_LIMIT) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin : stim
    repeat (3) step();
    rst = 1'b0;
    @(negedge clk);
    chk("R9 reset sre", sre_rd, 8'h00);
    chk("R9 reset srq", {7'b0, srq_out}, 8'h00);

    // flags and event summaries, no enable yet
    err_q_nonempty = 1'b1; step();
    out_q_nonempty = 1'b1; step();
    std_evt = 8'h10; std_evt_en = 8'h01; step();
    std_evt_en = 8'h11; step();
    ext_evt = 8'h80; ext_evt_en = 8'h80; step();
    ext_evt_en = 8'h7F; step();
    chk("R4 no enable", {7'b0, query_byte[6]}, 8'h00);
    err_q_nonempty = 1'b0; out_q_nonempty = 1'b0;
    std_evt = '0; ext_evt = '0; step();

    // bit 6 of the enable register is ignored
    write_sre(8'h40);
    chk("R5 bit6 dropped", sre_rd, 8'h00);
    write_sre(8'hFF);
    chk("R5 readback", sre_rd, 8'hBF);
    write_sre(8'h04);

    // rise sets the latch
    err_q_nonempty = 1'b1; step();
    chk("R6 set on rise", {7'b0, srq_out}, 8'h01);
    // poll strobe: byte carries latch, then clears
    poll_stb = 1'b1;
    #1;
    chk("R7 poll byte bit6", {7'b0, poll_byte[6]}, 8'h01);
    step();
    poll_stb = 1'b0;
    chk("R7 cleared after poll", {7'b0, srq_out}, 8'h00);
    step(); step();
    chk("R8 no re-set while high", {7'b0, srq_out}, 8'h00);
    err_q_nonempty = 1'b0; step();
    err_q_nonempty = 1'b1; step();
    chk("R6 set again", {7'b0, srq_out}, 8'h01);
    // summary drop clears
    err_q_nonempty = 1'b0; step();
    chk("R8 cleared on fall", {7'b0, srq_out}, 8'h00);
    // poll at the rising edge wins
    err_q_nonempty = 1'b1; poll_stb = 1'b1; step();
    poll_stb = 1'b0;
    chk("R7 poll beats rise", {7'b0, srq_out}, 8'h00);
    step();
    chk("R8 stays clear", {7'b0, srq_out}, 8'h00);
    err_q_nonempty = 1'b0;
    // event summary as request source
    write_sre(8'h20);
    std_evt = 8'h02; std_evt_en = 8'h02; step();
    chk("R6 via event summary", {7'b0, srq_out}, 8'h01);

    // random phase
    for (int i = 0; i < 2000; i++) begin
      err_q_nonempty = ($urandom % 4) == 0;
      out_q_nonempty = ($urandom % 4) == 0;
      std_evt    = 8'($urandom); std_evt_en = 8'($urandom % 3 == 0 ? $urandom : 0);
      ext_evt    = 8'($urandom); ext_evt_en = 8'($urandom % 3 == 0 ? $urandom : 0);
      poll_stb   = ($urandom % 5) == 0;
      sre_wr_en  = ($urandom % 8) == 0;
      sre_wr_data = 8'($urandom);
      step();
    end
    sre_wr_en = 1'b0; poll_stb = 1'b0;

    // reset in mid-run
    write_sre(8'h3C);
    err_q_nonempty = 1'b1; step();
    rst = 1'b1; step();
    rst = 1'b0;
    chk("R9 mid-run reset sre", sre_rd, 8'h00);
    chk("R9 mid-run reset srq", {7'b0, srq_out}, 8'h00);
    step();

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule